// File: doc/BRIEF.md
# Index-Ordered Min/Max and Logic Unit

This block is an execute-stage arithmetic unit for a compact instruction encoding in which a single opcode covers both minimum and maximum. The opcode itself does not say which of the two to compute. That choice comes from comparing the two source register numbers. If the first source index is larger than the second, the unit returns the smaller operand. If it is smaller, the unit returns the larger operand. If both indices name the same register, the encoding is reserved and the unit raises an illegal-instruction flag. A sign-mode input chooses between two's-complement comparison and unsigned comparison.

The same ordering rule can also extend the bitwise AND, OR and XOR operations. When a separate enable input is high and the first source index is at least the second, these operations produce NAND, NOR and XNOR instead. The unit is purely combinational, so its outputs are valid in the same cycle as its inputs. The surrounding pipeline supplies the decoded fields and the operand values, and it consumes the result and the flags. There are no state registers, so the house state-machine layout reduces to a decode stage followed by an output mux.

Top module: `ordmm_unit`

## Requirements
- R1: With `op_i` = 2'b00 (min/max), `valid_i` high and `rs1_idx_i` numerically greater than `rs2_idx_i`, `result_o` is the lesser of `src1_i` and `src2_i` and `alt_sel_o` is 1.
- R2: With `op_i` = 2'b00, `valid_i` high and `rs1_idx_i` numerically less than `rs2_idx_i`, `result_o` is the greater of the two operands and `alt_sel_o` is 0.
- R3: With `op_i` = 2'b00, `valid_i` high and equal source indices, `illegal_o` is 1, `result_o` is zero and `alt_sel_o` is 0. No other input combination raises `illegal_o`.
- R4: With `signed_i` = 0 the operands compare as unsigned values. For example, 0xFFFFFFFF is greater than 0x00000001.
- R5: With `signed_i` = 1 the operands compare as two's-complement values. 0x80000000 is the most negative value and is never returned as the maximum of two different values.
- R6: When both operands hold the same value in different registers, `result_o` equals that value.
- R7: With `logic_ext_en_i` = 1, `op_i` = 2'b01/2'b10/2'b11 selects AND/OR/XOR. If `rs1_idx_i` >= `rs2_idx_i`, the bitwise inverse is returned and `alt_sel_o` is 1. Otherwise the plain result is returned and `alt_sel_o` is 0.
- R8: With `logic_ext_en_i` = 0, the logic ops return the plain AND/OR/XOR for every index pair, with `alt_sel_o` = 0 and `illegal_o` = 0.
- R9: With `valid_i` = 0, `result_o`, `alt_sel_o` and `illegal_o` are all zero.
- R10: The outputs follow the inputs within the same cycle; the unit holds no state between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 min/max, 01 AND, 10 OR, 11 XOR |
| signed_i | input | 1 | 1 = two's-complement compare for min/max |
| logic_ext_en_i | input | 1 | Enables index-ordered inversion of logic ops |
| rs1_idx_i | input | 5 | First source register number |
| rs2_idx_i | input | 5 | Second source register number |
| src1_i | input | 32 | Value read from the first source |
| src2_i | input | 32 | Value read from the second source |
| result_o | output | 32 | Operation result, zero when not firing |
| alt_sel_o | output | 1 | 1 when min (or an inverted logic form) was chosen |
| illegal_o | output | 1 | Reserved encoding detected |

## Verification
The assertions are sampled inside combinational processes. They assume the index fields and operands are stable, known values for the whole cycle, and that `op_i` only ever carries one of the four defined codes. The bench respects both assumptions: it drives every input just after a rising edge, holds it for the full period, and only ever uses 2-bit op codes. It sweeps every one of the 1024 index pairs under each sign mode and logic-extension setting. The operands are drawn from a pool that mixes random words with 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and a share of the vectors repeat one operand into both sources.

// File: rtl/ordmm_pkg.sv
package ordmm_pkg;

    typedef enum logic [1:0] {
        OP_MINMAX = 2'b00,
        OP_AND    = 2'b01,
        OP_OR     = 2'b10,
        OP_XOR    = 2'b11
    } ordmm_op_e;

endpackage

// File: rtl/ordmm_decode.sv
module ordmm_decode
    import ordmm_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             valid_i,
    input  ordmm_op_e        op_i,
    input  logic             ext_en_i,
    input  logic [IDX_W-1:0] rs1_i,
    input  logic [IDX_W-1:0] rs2_i,
    output logic             is_minmax_o,
    output logic             alt_o,
    output logic             illegal_o,
    output logic             fire_o
);

    logic idx_gt;
    logic idx_eq;

    // Ordinal comparison of the two source register numbers.
    assign idx_gt = rs1_i > rs2_i;
    assign idx_eq = rs1_i == rs2_i;

    always_comb begin
        is_minmax_o = 1'b0;
        alt_o       = 1'b0;
        unique case (op_i)
            OP_MINMAX: begin
                is_minmax_o = 1'b1;
                alt_o       = idx_gt;
            end
            OP_AND, OP_OR, OP_XOR: begin
                alt_o = ext_en_i & (idx_gt | idx_eq);
            end
            default: alt_o = 1'b0;
        endcase
    end

    // Equal indices are reserved for min/max only.
    assign illegal_o = valid_i & is_minmax_o & idx_eq;
    assign fire_o    = valid_i & ~illegal_o;

endmodule

// File: rtl/ordmm_minmax.sv
module ordmm_minmax #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_i,
    input  logic              want_min_i,
    output logic [DATA_W-1:0] y_o
);

    logic a_lt_b;

    always_comb begin
        if (signed_i) begin
            a_lt_b = $signed(a_i) < $signed(b_i);
        end else begin
            a_lt_b = a_i < b_i;
        end
    end

    always_comb begin
        if (want_min_i) begin
            y_o = a_lt_b ? a_i : b_i;
        end else begin
            y_o = a_lt_b ? b_i : a_i;
        end
    end

endmodule

// File: rtl/ordmm_logic.sv
module ordmm_logic
    import ordmm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  ordmm_op_e         op_i,
    input  logic              invert_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    logic [DATA_W-1:0] base;

    always_comb begin
        unique case (op_i)
            OP_AND:  base = a_i & b_i;
            OP_OR:   base = a_i | b_i;
            OP_XOR:  base = a_i ^ b_i;
            default: base = '0;
        endcase
    end

    assign y_o = invert_i ? ~base : base;

endmodule

// File: rtl/ordmm_unit.sv
module ordmm_unit
    import ordmm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              valid_i,
    input  logic [1:0]        op_i,
    input  logic              signed_i,
    input  logic              logic_ext_en_i,
    input  logic [IDX_W-1:0]  rs1_idx_i,
    input  logic [IDX_W-1:0]  rs2_idx_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [DATA_W-1:0] src2_i,
    output logic [DATA_W-1:0] result_o,
    output logic              alt_sel_o,
    output logic              illegal_o
);

    ordmm_op_e         op;
    logic              is_minmax;
    logic              alt_raw;
    logic              fire;
    logic [DATA_W-1:0] mm_y;
    logic [DATA_W-1:0] lg_y;

    assign op = ordmm_op_e'(op_i);

    ordmm_decode #(.IDX_W(IDX_W)) u_decode (
        .valid_i    (valid_i),
        .op_i       (op),
        .ext_en_i   (logic_ext_en_i),
        .rs1_i      (rs1_idx_i),
        .rs2_i      (rs2_idx_i),
        .is_minmax_o(is_minmax),
        .alt_o      (alt_raw),
        .illegal_o  (illegal_o),
        .fire_o     (fire)
    );

    ordmm_minmax #(.DATA_W(DATA_W)) u_minmax (
        .a_i       (src1_i),
        .b_i       (src2_i),
        .signed_i  (signed_i),
        .want_min_i(alt_raw),
        .y_o       (mm_y)
    );

    ordmm_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i    (op),
        .invert_i(alt_raw),
        .a_i     (src1_i),
        .b_i     (src2_i),
        .y_o     (lg_y)
    );

    always_comb begin
        if (!fire) begin
            result_o = '0;
        end else if (is_minmax) begin
            result_o = mm_y;
        end else begin
            result_o = lg_y;
        end
    end

    assign alt_sel_o = fire & alt_raw;

    // Checks on the combined outputs.
    always_comb begin
        // R3
        illegal_quiet_chk: assert (!illegal_o || (result_o == '0 && !alt_sel_o));
        // R9
        idle_zero_chk: assert (valid_i || (result_o == '0 && !alt_sel_o && !illegal_o));
        // R1
        if (valid_i && op_i == 2'b00 && rs1_idx_i > rs2_idx_i) begin
            min_bound_chk: assert (signed_i
                ? ($signed(result_o) <= $signed(src1_i) && $signed(result_o) <= $signed(src2_i))
                : (result_o <= src1_i && result_o <= src2_i));
        end
        // R2
        if (valid_i && op_i == 2'b00 && rs1_idx_i < rs2_idx_i) begin
            max_bound_chk: assert (signed_i
                ? ($signed(result_o) >= $signed(src1_i) && $signed(result_o) >= $signed(src2_i))
                : (result_o >= src1_i && result_o >= src2_i));
        end
        // R6
        if (valid_i && op_i == 2'b00 && rs1_idx_i != rs2_idx_i) begin
            pick_operand_chk: assert (result_o == src1_i || result_o == src2_i);
        end
        // R8
        if (op_i != 2'b00 && !logic_ext_en_i) begin
            plain_logic_chk: assert (!alt_sel_o && !illegal_o);
        end
    end

endmodule

// File: tb/ordmm_unit_tb.sv
module ordmm_unit_tb;

    logic        clk = 1'b0;
    logic        valid;
    logic [1:0]  op;
    logic        sgn;
    logic        ext;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        alt;
    logic        ill;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ordmm_unit u_dut (
        .valid_i       (valid),
        .op_i          (op),
        .signed_i      (sgn),
        .logic_ext_en_i(ext),
        .rs1_idx_i     (rs1),
        .rs2_idx_i     (rs2),
        .src1_i        (a),
        .src2_i        (b),
        .result_o      (res),
        .alt_sel_o     (alt),
        .illegal_o     (ill)
    );

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    task automatic drive(input logic v, input logic [1:0] o, input logic s, input logic e,
                         input logic [4:0] i1, input logic [4:0] i2,
                         input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        #1;
        valid = v; op = o; sgn = s; ext = e;
        rs1 = i1; rs2 = i2; a = x; b = y;
    endtask

    // Outputs are sampled at the falling edge of the same cycle (R10).
    task automatic expect_out(input string req, input logic [31:0] er,
                              input logic ea, input logic ei);
        @(negedge clk);
        checks++;
        if (res !== er || alt !== ea || ill !== ei) begin
            errors++;
            $display("FAIL %s: op=%0d s=%0b e=%0b rs1=%0d rs2=%0d a=%h b=%h got res=%h alt=%0b ill=%0b exp res=%h alt=%0b ill=%0b",
                     req, op, sgn, ext, rs1, rs2, a, b, res, alt, ill, er, ea, ei);
        end
    endtask

    task automatic run_vec(input logic [1:0] o, input logic s, input logic e,
                           input logic [4:0] i1, input logic [4:0] i2,
                           input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er;
        logic        ea;
        logic        ei;
        logic        lt;
        logic [31:0] base;
        string       req;
        drive(1'b1, o, s, e, i1, i2, x, y);
        er = '0; ea = 1'b0; ei = 1'b0;
        if (o == 2'b00) begin
            lt = s ? ($signed(x) < $signed(y)) : (x < y);
            if (i1 == i2) begin
                ei = 1'b1; req = "R3";
            end else if (i1 > i2) begin
                er = lt ? x : y; ea = 1'b1;
                req = (x == y) ? "R6" : (s ? "R1/R5" : "R1/R4");
            end else begin
                er = lt ? y : x;
                req = (x == y) ? "R6" : (s ? "R2/R5" : "R2/R4");
            end
        end else begin
            base = (o == 2'b01) ? (x & y) : (o == 2'b10) ? (x | y) : (x ^ y);
            if (e && i1 >= i2) begin
                er = ~base; ea = 1'b1;
            end else begin
                er = base;
            end
            req = e ? "R7" : "R8";
        end
        expect_out(req, er, ea, ei);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout exp finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        valid = 1'b0; op = 2'b00; sgn = 1'b0; ext = 1'b0;
        rs1 = '0; rs2 = '0; a = '0; b = '0;

        // R9: idle state, even with a reserved-looking encoding present
        drive(1'b0, 2'b00, 1'b1, 1'b1, 5'd4, 5'd4, 32'h1234_5678, 32'h9ABC_DEF0);
        expect_out("R9", 32'h0, 1'b0, 1'b0);
        drive(1'b0, 2'b11, 1'b0, 1'b1, 5'd9, 5'd2, 32'hFFFF_0000, 32'h00FF_FF00);
        expect_out("R9", 32'h0, 1'b0, 1'b0);

        // Boundary cases
        run_vec(2'b00, 1'b0, 1'b0, 5'd3, 5'd7, 32'hFFFF_FFFF, 32'h0000_0001); // R4 max
        run_vec(2'b00, 1'b0, 1'b0, 5'd7, 5'd3, 32'hFFFF_FFFF, 32'h0000_0001); // R4 min
        run_vec(2'b00, 1'b1, 1'b0, 5'd1, 5'd2, 32'h8000_0000, 32'h0000_0005); // R5 max
        run_vec(2'b00, 1'b1, 1'b0, 5'd2, 5'd1, 32'h8000_0000, 32'h7FFF_FFFF); // R5 min
        run_vec(2'b00, 1'b1, 1'b0, 5'd0, 5'd31, 32'h8000_0000, 32'hFFFF_FFFF); // R5 max
        run_vec(2'b00, 1'b0, 1'b0, 5'd31, 5'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF); // R6
        run_vec(2'b00, 1'b1, 1'b0, 5'd12, 5'd12, 32'h1, 32'h2);                // R3
        run_vec(2'b10, 1'b0, 1'b1, 5'd12, 5'd12, 32'hF0F0_0000, 32'h0F0F_0000); // R7 equal -> NOR

        // Exhaustive index sweep per configuration
        for (int cfg = 0; cfg < 8; cfg++) begin
            logic [1:0] o;
            logic       s;
            logic       e;
            o = (cfg < 2) ? 2'b00 : 2'((cfg - 2) / 2 + 1);
            s = (cfg < 2) ? cfg[0] : 1'b0;
            e = (cfg < 2) ? 1'b0 : cfg[0];
            for (int i = 0; i < 32; i++) begin
                for (int j = 0; j < 32; j++) begin
                    logic [31:0] x;
                    logic [31:0] y;
                    x = pick();
                    y = (($urandom % 6) == 0) ? x : pick();
                    run_vec(o, s, e, 5'(i), 5'(j), x, y);
                end
            end
            drive(1'b0, o, s, e, 5'd20, 5'd10, pick(), pick());
            expect_out("R9", 32'h0, 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule